// File: doc/BRIEF.md
# Accumulator Store Output Shifter

This block turns a 32-bit accumulator value into a 16-bit word ready for a memory write. A select input picks either the upper or the lower half of the accumulator. The chosen half is shifted left by 0 to 7 places while it is handed over. The accumulator value is only an input here, so the block never writes back to it.

The two halves fill the vacated bits differently. When the upper half is stored, the bits that enter at the bottom are the top bits of the lower half. This makes the upper half and the lower half act as one continuous 32-bit word. When the lower half is stored, zeros enter at the bottom. In both cases the bits that leave at the top are dropped.

A store request captures the result into an output register. The word appears one clock later, together with a one-cycle valid strobe. Between requests the register keeps the last word.

Top module: `accst_store_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, `store_valid` is 0 and `store_word` is 0 after that edge.
- R2: `store_valid` is 1 in exactly the cycle after a clock edge at which `store_req` was 1. After an edge with `store_req` at 0, it is 0.
- R3: With `sel_high`=1 and shift count s, `store_word` equals bits [31-s : 16-s] of `acc_in`. Its s lowest bits are therefore the s most significant bits of the lower half.
- R4: With `sel_high`=0 and shift count s, `store_word` equals `acc_in[15:0]` shifted left by s. The s lowest bits are 0 and the top s bits of the lower half are lost.
- R5: With a shift count of 0, `store_word` is the selected half exactly: `acc_in[31:16]` for `sel_high`=1, or `acc_in[15:0]` for `sel_high`=0.
- R6: After a clock edge with `store_req` at 0, `store_word` keeps its previous value, whatever `acc_in`, `sel_high` and `shift_amt` are.
- R7: The maximum count of 7 is handled by the same rules as R3 and R4. For the upper half this gives `acc_in[24:9]`. For the lower half it gives `{acc_in[8:0], 7'b0}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| store_req | input | 1 | Capture a shifted word at this edge |
| sel_high | input | 1 | 1 selects the upper half, 0 selects the lower half |
| shift_amt | input | 3 | Left shift count, 0 to 7 |
| acc_in | input | 32 | Accumulator value |
| store_word | output | 16 | Registered shifted half |
| store_valid | output | 1 | High for one cycle after each request |

## Verification
Only two registers hold state. A wrong stage in the shift network or a wrong fill source shows up as a wrong `store_word` on the very next valid strobe. It only appears for the shift counts whose bit drives the faulty stage, so the bench covers all eight counts on both halves. A wrong valid or hold register shows up one cycle after a request or an idle edge: `store_valid` is stuck, or `store_word` drifts while no request is present.

// File: rtl/accst_pkg.sv
package accst_pkg;
  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_sel_e;
endpackage

// File: rtl/accst_window.sv
// Builds the double-width source word that the shifter works on.
// Upper half: the whole accumulator, so low-half MSBs feed the vacated bits.
// Lower half: the lower half on top of a zero field, so zeros feed in.
module accst_window
  import accst_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int ACC_W = 2 * HALF_W
) (
  input  logic [ACC_W-1:0] acc,
  input  half_sel_e        half,
  output logic [ACC_W-1:0] src
);
  always_comb begin
    if (half == HALF_HIGH) src = acc;
    else                   src = {acc[HALF_W-1:0], {HALF_W{1'b0}}};
  end
endmodule

// File: rtl/accst_barrel.sv
// Logarithmic left shifter: stage k shifts by 2**k when count bit k is set.
module accst_barrel #(
  parameter int W       = 32,
  parameter int SHIFT_W = 3
) (
  input  logic [W-1:0]       din,
  input  logic [SHIFT_W-1:0] count,
  output logic [W-1:0]       dout
);
  logic [W-1:0] stage [0:SHIFT_W];
  assign stage[0] = din;
  for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = count[k] ? (stage[k] << STEP) : stage[k];
  end
  assign dout = stage[SHIFT_W];
endmodule

// File: rtl/accst_outreg.sv
module accst_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) q <= d;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!valid && q == '0));
  assert_valid_after_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> valid);
  assert_no_valid_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> !valid);
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/accst_store_shifter.sv
module accst_store_shifter
  import accst_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int SHIFT_W = 3,
  localparam int ACC_W  = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               store_req,
  input  logic               sel_high,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic [ACC_W-1:0]   acc_in,
  output logic [HALF_W-1:0]  store_word,
  output logic               store_valid
);
  logic [ACC_W-1:0] src;
  logic [ACC_W-1:0] shifted;
  half_sel_e        half;

  assign half = sel_high ? HALF_HIGH : HALF_LOW;

  accst_window #(.HALF_W(HALF_W)) window_i (
    .acc  (acc_in),
    .half (half),
    .src  (src)
  );

  accst_barrel #(.W(ACC_W), .SHIFT_W(SHIFT_W)) barrel_i (
    .din   (src),
    .count (shift_amt),
    .dout  (shifted)
  );

  accst_outreg #(.W(HALF_W)) outreg_i (
    .clk   (clk),
    .rst   (rst),
    .load  (store_req),
    .d     (shifted[ACC_W-1 -: HALF_W]),
    .q     (store_word),
    .valid (store_valid)
  );

  assert_high_fill_from_low_R3: assert property (@(posedge clk) disable iff (rst)
    (store_req && sel_high && shift_amt != '0) |=>
      store_word[0] == $past(acc_in[HALF_W - int'(shift_amt)]));
  assert_low_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (store_req && !sel_high && shift_amt != '0) |=> store_word[0] == 1'b0);
  assert_zero_shift_high_R5: assert property (@(posedge clk) disable iff (rst)
    (store_req && sel_high && shift_amt == '0) |=>
      store_word == $past(acc_in[ACC_W-1:HALF_W]));
  assert_zero_shift_low_R5: assert property (@(posedge clk) disable iff (rst)
    (store_req && !sel_high && shift_amt == '0) |=>
      store_word == $past(acc_in[HALF_W-1:0]));
endmodule

// File: tb/accst_store_shifter_tb_top.sv
module accst_store_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        store_req = 1'b0;
  logic        sel_high = 1'b0;
  logic [2:0]  shift_amt = '0;
  logic [31:0] acc_in = '0;
  logic [15:0] store_word;
  logic        store_valid;

  int checks = 0;
  int failures = 0;
  logic        exp_valid = 1'b0;
  logic [15:0] exp_word = '0;

  always #10 clk = ~clk;

  accst_store_shifter dut_i (
    .clk(clk), .rst(rst), .store_req(store_req), .sel_high(sel_high),
    .shift_amt(shift_amt), .acc_in(acc_in),
    .store_word(store_word), .store_valid(store_valid)
  );

  function automatic logic [15:0] model_word(logic hi, int sh, logic [31:0] a);
    longint v;
    if (hi) v = (longint'(a) << sh) >> 16;
    else    v = longint'(a[15:0]) << sh;
    return 16'(v & 64'hFFFF);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (store_valid !== exp_valid || store_word !== exp_word) begin
      failures++;
      $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
               tag, store_valid, store_word, exp_valid, exp_word);
    end
  endtask

  // Drive one cycle, advance the reference model, compare after the edge.
  task automatic step(logic r, logic req, logic hi, int sh, logic [31:0] a);
    string tag;
    @(negedge clk);
    rst = r; store_req = req; sel_high = hi; shift_amt = 3'(sh); acc_in = a;
    @(posedge clk);
    if (r) begin
      exp_valid = 1'b0; exp_word = '0; tag = "R1";
    end else begin
      exp_valid = req;
      if (req) exp_word = model_word(hi, sh, a);
      if (!req)       tag = "R6/R2";
      else if (sh == 0) tag = "R5";
      else if (sh == 7) tag = "R7";
      else if (hi)    tag = "R3";
      else            tag = "R4";
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pats [4] = '{32'h8421_F0C3, 32'hFFFF_0001, 32'h1234_5678, 32'h0000_FFFF};
    // R1: reset clears outputs even with a request present
    step(1, 1, 1, 3, 32'hDEAD_BEEF);
    step(1, 1, 0, 5, 32'hDEAD_BEEF);
    // R3 R4 R5 R7: all counts on both halves, several patterns
    foreach (pats[p]) begin
      for (int sh = 0; sh < 8; sh++) begin
        step(0, 1, 1, sh, pats[p]);
        step(0, 1, 0, sh, pats[p]);
      end
    end
    // R6 and R2: idle cycles with changing inputs keep the word, drop valid
    step(0, 1, 1, 4, 32'hA5A5_3C3C);
    step(0, 0, 0, 7, 32'hFFFF_FFFF);
    step(0, 0, 1, 1, 32'h0000_0000);
    // R2: isolated request pulses
    step(0, 1, 0, 2, 32'h0000_C001);
    step(0, 0, 1, 2, 32'h7777_7777);
    // R3: high half pulls low-half MSBs; R7: max count
    step(0, 1, 1, 7, 32'h0000_FF80);
    step(0, 1, 0, 7, 32'h0000_01FF);
    // R1: reset mid-stream
    step(1, 1, 1, 1, 32'h1111_2222);
    step(0, 0, 1, 1, 32'h1111_2222);
    step(0, 1, 1, 1, 32'h8000_8000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule